// File: doc/BRIEF.md
# Submodule Capacitor Voltage Protection Monitor

This block watches a serial stream of capacitor voltage samples, one submodule per clock cycle. Each sample carries a submodule index, a capacitor voltage, the submodule's four input gate signals and its 16-bit internal state word. Three detectors check every sample:

- overvoltage stage 1, which trips when the voltage is strictly above its threshold;
- overvoltage stage 2, which also trips when the voltage is strictly above its threshold;
- undervoltage, which trips when the voltage is strictly below its threshold.

Each detector has its own enable, its own threshold and its own hold option. The result comes out one cycle later. It carries the updated state word and the gates to apply to the submodule. An active stage-1 overvoltage replaces the input gates with a fixed bypass pattern. The other two detectors report status only.

Hold memory is kept for every submodule and every detector. It has two named states:

- HOLD_CLEAR: the flag follows the live comparison.
- HOLD_SET: the flag stays asserted even after the voltage has returned to the safe side.

The transitions are:

- HOLD_CLEAR to HOLD_SET (ARM): the detector is enabled, its hold option is on and the comparison trips.
- HOLD_SET to HOLD_CLEAR (RELEASE): the hold option is off and the voltage is on the safe side.
- HOLD_SET to HOLD_CLEAR (DISARM): the detector is disabled.
- All other cases keep the current state.

Only the submodule named by a valid sample has its hold state read and rewritten, and this happens in the cycle that processes that sample.

Voltages and thresholds are unsigned fixed point with 13 fractional bits, so 1.0 per-unit is 8192.

Top module: `cvp_monitor`

## Requirements
- R1: After reset, m_valid is 0, m_gates, m_state, m_sm and m_bypass are 0, and every hold state is HOLD_CLEAR. A first safe sample therefore reports no flag even with holding on.
- R2: With stage-1 enabled, state bit 10 of the output is 1 exactly when the effective voltage is above threshold ov1 (equal does not trip), or when the hold state is HOLD_SET.
- R3: With stage-2 enabled, state bit 11 follows the same rule against threshold ov2.
- R4: With undervoltage enabled, state bit 12 is 1 exactly when the voltage is below threshold uv (equal does not trip), or when the hold state is HOLD_SET.
- R5: A disabled detector outputs 0 in its bit and forces its stored hold state to HOLD_CLEAR. After it is re-enabled, a safe sample reports 0.
- R6: With the hold option on, a tripped flag stays 1 on later safe samples of the same submodule. Other submodules are not affected.
- R7: A held flag clears only when its hold option is off and the sample is safe. With the hold option off and the sample still unsafe, the flag stays 1, and the next safe sample clears it.
- R8: When output bit 10 is 1, m_bypass is 1 and m_gates is the bypass pattern 4'b0010 (only gate 2 on, gates 1, 3 and 4 off).
- R9: When output bit 10 is 0, m_gates equals the sample's input gates and m_bypass is 0, whatever bits 11 and 12 are.
- R10: Overvoltage thresholds above 4.0 per-unit (32768) act as exactly 32768.
- R11: All state bits other than 10, 11 and 12 pass through unchanged, and m_sm echoes the sample's index.
- R12: Every result appears exactly one cycle after its sample (m_valid follows s_valid one cycle later), and back-to-back samples of the same submodule see the hold state written by the previous one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| s_valid | input | 1 | Sample present this cycle |
| s_sm | input | SMW | Submodule index of the sample |
| s_vcap | input | VW | Capacitor voltage, unsigned, FRAC fractional bits |
| s_gates | input | 4 | Input gate signals, bit 0 = gate 1 |
| s_state | input | 16 | Submodule state word before update |
| cfg_ov1_en | input | 1 | Stage-1 overvoltage detector enable |
| cfg_ov1_hold | input | 1 | Stage-1 hold option |
| cfg_ov1_thr | input | VW | Stage-1 threshold |
| cfg_ov2_en | input | 1 | Stage-2 overvoltage detector enable |
| cfg_ov2_hold | input | 1 | Stage-2 hold option |
| cfg_ov2_thr | input | VW | Stage-2 threshold |
| cfg_uv_en | input | 1 | Undervoltage detector enable |
| cfg_uv_hold | input | 1 | Undervoltage hold option |
| cfg_uv_thr | input | VW | Undervoltage threshold |
| m_valid | output | 1 | Result present |
| m_sm | output | SMW | Submodule index of the result |
| m_gates | output | 4 | Gates to apply, bypass pattern when stage-1 is active |
| m_bypass | output | 1 | Submodule forced into bypass |
| m_state | output | 16 | Updated state word |

## Verification
If a hold state is corrupted, it shows up at the ports on the very next sample of the same submodule. The flag appears or vanishes one cycle after that sample enters, and a stage-1 error also flips m_gates to or from the bypass pattern. An error in another submodule's hold entry stays invisible until that submodule is sampled. For this reason the stimulus revisits submodules whose hold states were set, released or disarmed, and compares every result against an independent model that covers the full state word and the gates.

// File: rtl/cvp_pkg.sv
package cvp_pkg;

    typedef enum logic {
        HOLD_CLEAR = 1'b0,
        HOLD_SET   = 1'b1
    } hold_e;

    localparam int DET_OV1 = 0;
    localparam int DET_OV2 = 1;
    localparam int DET_UV  = 2;
    localparam int N_DET   = 3;

    localparam int ST_W        = 16;
    localparam int ST_FLAG_LSB = 10;   // bits 10..12 hold OV1, OV2, UV
    localparam int GATE_W      = 4;
    localparam logic [GATE_W-1:0] BYPASS_GATES = 4'b0010;

endpackage

// File: rtl/cvp_thr_cmp.sv
module cvp_thr_cmp #(
    parameter int VW    = 16,
    parameter int FRAC  = 13,
    parameter bit OVER  = 1'b1
) (
    input  logic [VW-1:0] vcap,
    input  logic [VW-1:0] thr,
    output logic          trip
);
    localparam logic [VW:0] CAP = (VW+1)'(4) << FRAC;

    logic [VW:0] thr_eff;

    generate
        if (OVER) begin : g_over
            always_comb begin
                thr_eff = ({1'b0, thr} > CAP) ? CAP : {1'b0, thr};
                trip    = {1'b0, vcap} > thr_eff;
            end
        end else begin : g_under
            always_comb begin
                thr_eff = {1'b0, thr};
                trip    = {1'b0, vcap} < thr_eff;
            end
        end
    endgenerate
endmodule

// File: rtl/cvp_flag_fsm.sv
module cvp_flag_fsm
    import cvp_pkg::*;
(
    input  logic  en,
    input  logic  hold_opt,
    input  logic  trip,
    input  hold_e cur,
    output hold_e nxt,
    output logic  flag
);
    // next-state process
    always_comb begin
        nxt = cur;
        unique case (cur)
            HOLD_CLEAR: begin
                if (en && hold_opt && trip) nxt = HOLD_SET;      // ARM
            end
            HOLD_SET: begin
                if (!en)                      nxt = HOLD_CLEAR;  // DISARM
                else if (!hold_opt && !trip)  nxt = HOLD_CLEAR;  // RELEASE
            end
            default: nxt = HOLD_CLEAR;
        endcase
    end

    // output process
    always_comb begin
        flag = 1'b0;
        unique case (cur)
            HOLD_CLEAR: flag = en && trip;
            HOLD_SET:   flag = en;
            default:    flag = 1'b0;
        endcase
    end
endmodule

// File: rtl/cvp_hold_store.sv
module cvp_hold_store
    import cvp_pkg::*;
#(
    parameter int N_SM = 64,
    parameter int SMW  = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [SMW-1:0]   rd_idx,
    output logic [N_DET-1:0] rd_bits,
    input  logic             wr_en,
    input  logic [SMW-1:0]   wr_idx,
    input  logic [N_DET-1:0] wr_bits
);
    logic [N_DET-1:0] mem [N_SM];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < N_SM; i++) mem[i] <= '0;
        end else if (wr_en && (32'(wr_idx) < N_SM)) begin
            mem[wr_idx] <= wr_bits;
        end
    end

    always_comb begin
        rd_bits = '0;
        if (32'(rd_idx) < N_SM) rd_bits = mem[rd_idx];
    end
endmodule

// File: rtl/cvp_monitor.sv
module cvp_monitor
    import cvp_pkg::*;
#(
    parameter int N_SM = 64,
    parameter int VW   = 16,
    parameter int FRAC = 13,
    parameter int SMW  = (N_SM > 1) ? $clog2(N_SM) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              s_valid,
    input  logic [SMW-1:0]    s_sm,
    input  logic [VW-1:0]     s_vcap,
    input  logic [GATE_W-1:0] s_gates,
    input  logic [ST_W-1:0]   s_state,
    input  logic              cfg_ov1_en,
    input  logic              cfg_ov1_hold,
    input  logic [VW-1:0]     cfg_ov1_thr,
    input  logic              cfg_ov2_en,
    input  logic              cfg_ov2_hold,
    input  logic [VW-1:0]     cfg_ov2_thr,
    input  logic              cfg_uv_en,
    input  logic              cfg_uv_hold,
    input  logic [VW-1:0]     cfg_uv_thr,
    output logic              m_valid,
    output logic [SMW-1:0]    m_sm,
    output logic [GATE_W-1:0] m_gates,
    output logic              m_bypass,
    output logic [ST_W-1:0]   m_state
);
    localparam logic [ST_W-1:0] FLAG_MASK = ST_W'({N_DET{1'b1}}) << ST_FLAG_LSB;

    logic [N_DET-1:0]  det_en, det_hold, det_trip, det_flag;
    logic [VW-1:0]     det_thr [N_DET];
    logic [N_DET-1:0]  cur_bits, nxt_bits;

    assign det_en   = {cfg_uv_en,   cfg_ov2_en,   cfg_ov1_en};
    assign det_hold = {cfg_uv_hold, cfg_ov2_hold, cfg_ov1_hold};
    assign det_thr[DET_OV1] = cfg_ov1_thr;
    assign det_thr[DET_OV2] = cfg_ov2_thr;
    assign det_thr[DET_UV]  = cfg_uv_thr;

    cvp_hold_store #(.N_SM(N_SM), .SMW(SMW)) u_store (
        .clk     (clk),
        .rst_n   (rst_n),
        .rd_idx  (s_sm),
        .rd_bits (cur_bits),
        .wr_en   (s_valid),
        .wr_idx  (s_sm),
        .wr_bits (nxt_bits)
    );

    generate
        for (genvar d = 0; d < N_DET; d++) begin : g_det
            hold_e cur_st, nxt_st;
            assign cur_st = hold_e'(cur_bits[d]);
            assign nxt_bits[d] = nxt_st;

            cvp_thr_cmp #(.VW(VW), .FRAC(FRAC), .OVER(d != DET_UV)) u_cmp (
                .vcap (s_vcap),
                .thr  (det_thr[d]),
                .trip (det_trip[d])
            );

            cvp_flag_fsm u_fsm (
                .en       (det_en[d]),
                .hold_opt (det_hold[d]),
                .trip     (det_trip[d]),
                .cur      (cur_st),
                .nxt      (nxt_st),
                .flag     (det_flag[d])
            );
        end
    endgenerate

    logic [ST_W-1:0]   st_next;
    logic [GATE_W-1:0] gates_next;

    always_comb begin
        st_next    = (s_state & ~FLAG_MASK) | (ST_W'(det_flag) << ST_FLAG_LSB);
        gates_next = det_flag[DET_OV1] ? BYPASS_GATES : s_gates;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_valid  <= 1'b0;
            m_sm     <= '0;
            m_gates  <= '0;
            m_bypass <= 1'b0;
            m_state  <= '0;
        end else begin
            m_valid <= s_valid;
            if (s_valid) begin
                m_sm     <= s_sm;
                m_gates  <= gates_next;
                m_bypass <= det_flag[DET_OV1];
                m_state  <= st_next;
            end
        end
    end
endmodule

// File: rtl/cvp_monitor_chk.sv
module cvp_monitor_chk
    import cvp_pkg::*;
#(
    parameter int VW   = 16,
    parameter int FRAC = 13,
    parameter int SMW  = 6
) (
    input logic              clk,
    input logic              rst_n,
    input logic              s_valid,
    input logic [SMW-1:0]    s_sm,
    input logic [VW-1:0]     s_vcap,
    input logic [GATE_W-1:0] s_gates,
    input logic              cfg_ov1_en,
    input logic [VW-1:0]     cfg_ov1_thr,
    input logic              cfg_ov2_en,
    input logic              m_valid,
    input logic [SMW-1:0]    m_sm,
    input logic [GATE_W-1:0] m_gates,
    input logic              m_bypass,
    input logic [ST_W-1:0]   m_state
);
    localparam logic [VW:0] CAP = (VW+1)'(4) << FRAC;
    logic [VW:0] thr1_eff;
    assign thr1_eff = ({1'b0, cfg_ov1_thr} > CAP) ? CAP : {1'b0, cfg_ov1_thr};

    // R12
    valid_lat_chk: assert property (@(posedge clk) disable iff (!rst_n)
        s_valid |=> m_valid);
    // R12
    idle_lat_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !s_valid |=> !m_valid);
    // R11
    sm_echo_chk: assert property (@(posedge clk) disable iff (!rst_n)
        s_valid |=> m_sm == $past(s_sm));
    // R2
    ov1_trip_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (s_valid && cfg_ov1_en && ({1'b0, s_vcap} > thr1_eff)) |=> m_state[10]);
    // R5
    ov2_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (s_valid && !cfg_ov2_en) |=> !m_state[11]);
    // R8
    bypass_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (m_valid && m_state[10]) |-> (m_bypass && m_gates == BYPASS_GATES));
    // R9
    gate_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (s_valid && !cfg_ov1_en) |=> (!m_bypass && m_gates == $past(s_gates)));
endmodule

bind cvp_monitor cvp_monitor_chk #(.VW(VW), .FRAC(FRAC), .SMW(SMW)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .s_valid     (s_valid),
    .s_sm        (s_sm),
    .s_vcap      (s_vcap),
    .s_gates     (s_gates),
    .cfg_ov1_en  (cfg_ov1_en),
    .cfg_ov1_thr (cfg_ov1_thr),
    .cfg_ov2_en  (cfg_ov2_en),
    .m_valid     (m_valid),
    .m_sm        (m_sm),
    .m_gates     (m_gates),
    .m_bypass    (m_bypass),
    .m_state     (m_state)
);

// File: tb/cvp_monitor_tb.sv
module cvp_monitor_tb;
    localparam int N_SM = 64;
    localparam int VW   = 16;
    localparam int SMW  = 6;
    localparam int PU   = 8192;

    logic clk = 0;
    logic rst_n = 0;
    always #2.5 clk = ~clk;

    logic           s_valid = 0;
    logic [SMW-1:0] s_sm = 0;
    logic [VW-1:0]  s_vcap = 0;
    logic [3:0]     s_gates = 0;
    logic [15:0]    s_state = 0;
    logic ov1_en = 0, ov1_hold = 0, ov2_en = 0, ov2_hold = 0, uv_en = 0, uv_hold = 0;
    logic [VW-1:0] ov1_thr = 9830, ov2_thr = 9011, uv_thr = 6554;
    logic           m_valid, m_bypass;
    logic [SMW-1:0] m_sm;
    logic [3:0]     m_gates;
    logic [15:0]    m_state;

    cvp_monitor #(.N_SM(N_SM), .VW(VW), .FRAC(13)) u_dut (
        .clk(clk), .rst_n(rst_n), .s_valid(s_valid), .s_sm(s_sm), .s_vcap(s_vcap),
        .s_gates(s_gates), .s_state(s_state),
        .cfg_ov1_en(ov1_en), .cfg_ov1_hold(ov1_hold), .cfg_ov1_thr(ov1_thr),
        .cfg_ov2_en(ov2_en), .cfg_ov2_hold(ov2_hold), .cfg_ov2_thr(ov2_thr),
        .cfg_uv_en(uv_en), .cfg_uv_hold(uv_hold), .cfg_uv_thr(uv_thr),
        .m_valid(m_valid), .m_sm(m_sm), .m_gates(m_gates), .m_bypass(m_bypass),
        .m_state(m_state)
    );

    int checks = 0;
    int errors = 0;
    bit done = 0;

    logic [SMW-1:0] q_sm[$];
    logic [3:0]     q_gates[$];
    logic [15:0]    q_state[$];
    string          q_tag[$];

    bit held [3][N_SM];

    function automatic bit flag_step(int d, int sm, bit en, bit hold, bit trip);
        bit f;
        f = en && (trip || held[d][sm]);
        if (!en) held[d][sm] = 0;
        else if (hold && trip) held[d][sm] = 1;
        else if (!hold && !trip) held[d][sm] = 0;
        return f;
    endfunction

    task automatic send(input int sm, input int v, input logic [3:0] g,
                        input logic [15:0] st, input string tag);
        int t1, t2;
        bit f1, f2, f3;
        logic [15:0] exp_st;
        t1 = (ov1_thr > 32768) ? 32768 : int'(ov1_thr);
        t2 = (ov2_thr > 32768) ? 32768 : int'(ov2_thr);
        f1 = flag_step(0, sm, ov1_en, ov1_hold, v > t1);
        f2 = flag_step(1, sm, ov2_en, ov2_hold, v > t2);
        f3 = flag_step(2, sm, uv_en, uv_hold, v < int'(uv_thr));
        exp_st = (st & ~16'h1C00) | ({13'd0, f3, f2, f1} << 10);
        q_sm.push_back(SMW'(sm));
        q_gates.push_back(f1 ? 4'b0010 : g);
        q_state.push_back(exp_st);
        q_tag.push_back(tag);
        s_sm = SMW'(sm); s_vcap = VW'(v); s_gates = g; s_state = st; s_valid = 1;
        @(posedge clk); #1;
        s_valid = 0;
    endtask

    // monitor / scoreboard
    always @(negedge clk) begin
        if (rst_n && !done && m_valid) begin
            checks++;
            if (q_sm.size() == 0) begin
                errors++;
                $display("FAIL R12: unexpected result sm=%0d, expected none", m_sm);
            end else begin
                automatic logic [SMW-1:0] e_sm = q_sm.pop_front();
                automatic logic [3:0] e_g = q_gates.pop_front();
                automatic logic [15:0] e_st = q_state.pop_front();
                automatic string tg = q_tag.pop_front();
                if (m_sm !== e_sm || m_gates !== e_g || m_state !== e_st ||
                    m_bypass !== e_st[10]) begin
                    errors++;
                    $display("FAIL %s: sm=%0d gates=%b byp=%b state=%h, expected sm=%0d gates=%b byp=%b state=%h",
                             tg, m_sm, m_gates, m_bypass, m_state, e_sm, e_g, e_st[10], e_st);
                end
            end
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: run hung, expected completion");
            done = 1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1;
        checks++;
        if (m_valid !== 0 || m_gates !== 0 || m_state !== 0 || m_bypass !== 0 || m_sm !== 0) begin
            errors++;
            $display("FAIL R1: outputs %b %b %h %b, expected all zero", m_valid, m_gates, m_state, m_bypass);
        end
        rst_n = 1;
        @(posedge clk); #1;
        ov1_en = 1; ov2_en = 1; uv_en = 1;
        ov1_hold = 1; ov2_hold = 1; uv_hold = 1;
        send(9, PU, 4'b0101, 16'h0000, "R1 fresh hold clear");
        ov1_hold = 0; ov2_hold = 0; uv_hold = 0;
        send(0, PU, 4'b1001, 16'h0000, "R2 R3 R4 R9 nominal");
        send(1, 9830, 4'b0110, 16'hFFFF, "R2 equal no trip, R3 trip, R9 R11");
        send(2, 9831, 4'b1101, 16'hA5A5, "R2 R8 bypass");
        send(3, 6554, 4'b0001, 16'h0000, "R4 equal no trip");
        send(3, 6553, 4'b1111, 16'h1234, "R4 R9 undervoltage");
        ov1_hold = 1; ov2_hold = 1; uv_hold = 1;
        send(4, 10000, 4'b0001, 16'h0000, "R6 trip");
        send(4, PU, 4'b0001, 16'h0000, "R6 held");
        send(5, PU, 4'b0100, 16'h0000, "R6 other sm unaffected");
        send(6, 5000, 4'b0000, 16'hE3FF, "R4 R6 R11 uv trip");
        @(posedge clk); #1;
        send(6, PU, 4'b0000, 16'h0000, "R6 uv held after gap");
        ov1_hold = 0;
        send(4, 10000, 4'b0001, 16'h0000, "R7 hold off still unsafe");
        send(4, PU, 4'b0011, 16'h0000, "R7 released ov1, ov2 held");
        ov2_en = 0;
        send(4, 12000, 4'b0011, 16'h0000, "R5 ov2 disabled");
        ov2_en = 1;
        send(4, PU, 4'b0011, 16'h0000, "R5 held cleared");
        ov1_thr = 16'hF000;
        send(7, 32769, 4'b1000, 16'h0000, "R10 clamp trip");
        send(8, 32768, 4'b1000, 16'h0000, "R10 clamp equal");
        uv_hold = 0;
        send(6, PU, 4'b0000, 16'h0000, "R7 uv release");
        for (int i = 0; i < 20; i++)
            send(i % 3 + 10, 7000 + i * 700, 4'(i), 16'(i * 4099), "R12 back-to-back");
        repeat (4) @(posedge clk);
        #1;
        checks++;
        if (q_sm.size() != 0) begin
            errors++;
            $display("FAIL R12: %0d results missing, expected 0", q_sm.size());
        end
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule